// File: doc/BRIEF.md
# Display Mode Register Block

This block is the software-visible control surface of a simple linear-framebuffer display controller. It sits behind a 4 KiB memory-mapped window and decodes two small pages inside it. The mode page holds an array of 16-bit mode registers. Each register is selected by its halfword index, so the index is the byte offset within the page shifted right by one. The extension page holds two 32-bit words. One reports the size of the extension region. The other selects the byte order of the framebuffer. Downstream scan-out logic takes the stored mode values, the display-enable bit and the byte-order flag straight from the block's output ports.

The mode array stores ten halfwords. Index 0 always reads back a fixed identification code, whatever has been stored there. Index 10 is a read-only entry that reports the video memory size in 64 KiB units and has no storage behind it. Indices above 10 in the mode page read as all ones and ignore writes. The byte-order word is changed only by one of two exact magic values. All other addresses read as zero and ignore writes.

Reads go through a two-state response machine. `RS_IDLE` means no read data is presented. `RS_RESP` means the captured read data is valid. A read strobe moves the machine from either state to `RS_RESP` (the IDLE→RESP and RESP→RESP transitions). A cycle without a read strobe moves it to `RS_IDLE` (the RESP→IDLE and IDLE→IDLE transitions).

Top module: `dm_regif`

## Requirements
- R1: After reset, all ten stored mode registers are zero, the byte order is little-endian (`big_endian_o`=0) and `bus_rvalid` is low.
- R2: A read at byte address 0x500 (mode index 0) returns 0x0000B0C5, whatever was written there. A write there still updates the stored value exported at `mode_regs_o[15:0]`.
- R3: A read of mode index 10 (address 0x514) returns VRAM_BYTES/65536, which is 0x0100 by default, in the low 16 bits. Writes to index 10 change nothing.
- R4: Mode indices 1 to 9 sit at 0x500 + 2*index, and address bit 0 is ignored. A write stores `bus_wdata[15:0]`, and a later read returns that value zero-extended to 32 bits.
- R5: Mode indices 11 to 127 (0x516 to 0x5FF) read 0x0000FFFF, and writes there leave every exported register unchanged.
- R6: Extension offset 0 (address 0x600) reads 8.
- R7: A write of 0xBEBEBEBE to 0x604 selects big-endian, and a write of 0x1E1E1E1E selects little-endian. A read of 0x604 returns 0xBEBEBEBE when big-endian is selected and 0x1E1E1E1E otherwise.
- R8: Any other value written to 0x604 leaves the byte order unchanged.
- R9: Extension offsets other than 0 and 4 in page 0x6xx, and every address outside pages 0x5xx and 0x6xx, read 0 and ignore writes.
- R10: The response to a read strobe in cycle N appears on `bus_rdata` with `bus_rvalid` high in cycle N+1. `bus_rvalid` is low in a cycle that follows no read strobe. Back-to-back reads are answered every cycle.
- R11: A write appears on `mode_regs_o` (index i at bits [16i+15:16i]) in the cycle after the write. `display_en_o` is bit 0 of index 4 (address 0x508).
- R12: When a read and a write to the same register fall in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response valid |
| mode_regs_o | output | 160 | Ten stored mode registers, flattened |
| display_en_o | output | 1 | Display enable bit |
| big_endian_o | output | 1 | Framebuffer byte order, 1 = big-endian |

## Verification
The bench writes to index 0 and index 10. A design that let stored data shadow the ID or the memory-size value would return the written data from those reads. The byte-order word receives near-miss values such as 0xBEBEBEBF and 0x12345678. A design that tested only some bits, or stored any written value, would flip the flag on them. The bench also checks the edges of the mode page: index 11, index 127 and odd byte addresses. It probes unused extension offsets and foreign pages, where a loose decoder would alias into storage. Same-cycle read and write, and back-to-back reads, expose a response machine that returns new data or drops a valid cycle.

// File: rtl/dm_pkg.sv
package dm_pkg;
    localparam logic [15:0] DM_ID_VALUE  = 16'hB0C5;
    localparam logic [31:0] DM_MAGIC_BE  = 32'hBEBEBEBE;
    localparam logic [31:0] DM_MAGIC_LE  = 32'h1E1E1E1E;
    localparam int          DM_REG_BITS  = 16;
    localparam int          DM_EN_INDEX  = 4;
    localparam int          DM_EN_DISP   = 0;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_MODE = 2'd1,
        RG_EXT  = 2'd2
    } region_e;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_RESP = 1'b1
    } rsp_state_e;
endpackage

// File: rtl/dm_decode.sv
module dm_decode
    import dm_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int PAGE_BITS = 8,
    parameter int MODE_BASE = 'h500,
    parameter int EXT_BASE  = 'h600
) (
    input  logic [ADDR_W-1:0]    addr,
    output region_e              region,
    output logic [PAGE_BITS-2:0] mode_idx,
    output logic [PAGE_BITS-1:0] ext_off
);
    localparam int PG_W = ADDR_W - PAGE_BITS;
    localparam logic [PG_W-1:0] MODE_PG = PG_W'(MODE_BASE >> PAGE_BITS);
    localparam logic [PG_W-1:0] EXT_PG  = PG_W'(EXT_BASE >> PAGE_BITS);

    logic [PG_W-1:0] page;

    assign page     = addr[ADDR_W-1:PAGE_BITS];
    assign mode_idx = addr[PAGE_BITS-1:1];
    assign ext_off  = addr[PAGE_BITS-1:0];

    always_comb begin
        if (page == MODE_PG) begin
            region = RG_MODE;
        end else if (page == EXT_PG) begin
            region = RG_EXT;
        end else begin
            region = RG_NONE;
        end
    end
endmodule

// File: rtl/dm_mode_file.sv
module dm_mode_file
    import dm_pkg::*;
#(
    parameter int NREG      = 10,
    parameter int IDX_W     = 7,
    parameter int MEM_UNITS = 256
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      idx,
    input  logic [15:0]           wdata,
    output logic [15:0]           rd_val,
    output logic [NREG*16-1:0]    regs_flat
);
    localparam logic [15:0] MEM_VAL = 16'(MEM_UNITS);

    logic [15:0] reg_q [NREG];
    logic [15:0] sel_val;

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reg_q[gi] <= '0;
            end else if (wr_en && (int'(idx) == gi)) begin
                reg_q[gi] <= wdata;
            end
        end
        assign regs_flat[gi*16 +: 16] = reg_q[gi];
    end

    always_comb begin
        sel_val = '0;
        for (int i = 0; i < NREG; i++) begin
            if (int'(idx) == i) begin
                sel_val = reg_q[i];
            end
        end
    end

    always_comb begin
        if (idx == '0) begin
            rd_val = DM_ID_VALUE;
        end else if (int'(idx) < NREG) begin
            rd_val = sel_val;
        end else if (int'(idx) == NREG) begin
            rd_val = MEM_VAL;
        end else begin
            rd_val = 16'hFFFF;
        end
    end

    // R5: a write to an index without storage leaves all storage untouched
    p_nostore_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(idx) >= NREG)) |=> $stable(regs_flat));
endmodule

// File: rtl/dm_ext_reg.sv
module dm_ext_reg
    import dm_pkg::*;
#(
    parameter int OFF_W     = 8,
    parameter int EXT_SPAN  = 8,
    parameter int OFF_ORDER = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] off,
    input  logic [31:0]      wdata,
    output logic [31:0]      rd_val,
    output logic             big_q
);
    localparam logic [OFF_W-1:0] OFF_SIZE_W  = '0;
    localparam logic [OFF_W-1:0] OFF_ORDER_W = OFF_W'(OFF_ORDER);

    logic order_wr;

    assign order_wr = wr_en && (off == OFF_ORDER_W);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            big_q <= 1'b0;
        end else if (order_wr && (wdata == DM_MAGIC_BE)) begin
            big_q <= 1'b1;
        end else if (order_wr && (wdata == DM_MAGIC_LE)) begin
            big_q <= 1'b0;
        end
    end

    always_comb begin
        if (off == OFF_SIZE_W) begin
            rd_val = 32'(EXT_SPAN);
        end else if (off == OFF_ORDER_W) begin
            rd_val = big_q ? DM_MAGIC_BE : DM_MAGIC_LE;
        end else begin
            rd_val = '0;
        end
    end

    // R8: non-magic data written to the order word keeps the setting
    p_order_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (order_wr && (wdata != DM_MAGIC_BE) && (wdata != DM_MAGIC_LE))
        |=> $stable(big_q));

    // R7: the big-endian magic value always lands
    p_order_be_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (order_wr && (wdata == DM_MAGIC_BE)) |=> big_q);
endmodule

// File: rtl/dm_regif.sv
module dm_regif
    import dm_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int PAGE_BITS  = 8,
    parameter int MODE_BASE  = 'h500,
    parameter int EXT_BASE   = 'h600,
    parameter int NREG       = 10,
    parameter int VRAM_BYTES = 16 * 1024 * 1024
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    output logic [31:0]          bus_rdata,
    output logic                 bus_rvalid,
    output logic [NREG*16-1:0]   mode_regs_o,
    output logic                 display_en_o,
    output logic                 big_endian_o
);
    localparam int IDX_W     = PAGE_BITS - 1;
    localparam int MEM_UNITS = VRAM_BYTES / 65536;

    region_e              region;
    logic [IDX_W-1:0]     mode_idx;
    logic [PAGE_BITS-1:0] ext_off;
    logic [15:0]          mode_rd;
    logic [31:0]          ext_rd;
    logic [31:0]          rd_mux;
    logic                 wr_mode;
    logic                 wr_ext;
    rsp_state_e           state_q;
    rsp_state_e           state_d;
    logic [31:0]          rdata_q;

    dm_decode #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
        .MODE_BASE(MODE_BASE), .EXT_BASE(EXT_BASE)
    ) u_decode (
        .addr(bus_addr), .region(region),
        .mode_idx(mode_idx), .ext_off(ext_off)
    );

    assign wr_mode = bus_wr && (region == RG_MODE);
    assign wr_ext  = bus_wr && (region == RG_EXT);

    dm_mode_file #(
        .NREG(NREG), .IDX_W(IDX_W), .MEM_UNITS(MEM_UNITS)
    ) u_mode (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_mode), .idx(mode_idx),
        .wdata(bus_wdata[15:0]), .rd_val(mode_rd), .regs_flat(mode_regs_o)
    );

    dm_ext_reg #(
        .OFF_W(PAGE_BITS), .EXT_SPAN(8), .OFF_ORDER(4)
    ) u_ext (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ext), .off(ext_off),
        .wdata(bus_wdata), .rd_val(ext_rd), .big_q(big_endian_o)
    );

    always_comb begin
        case (region)
            RG_MODE: rd_mux = {16'h0000, mode_rd};
            RG_EXT:  rd_mux = ext_rd;
            default: rd_mux = '0;
        endcase
    end

    // response state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: state_d = bus_rd ? RS_RESP : RS_IDLE;
            RS_RESP: state_d = bus_rd ? RS_RESP : RS_IDLE;
        endcase
    end

    // output process: capture read data with the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata    = rdata_q;
    assign bus_rvalid   = (state_q == RS_RESP);
    assign display_en_o = mode_regs_o[DM_EN_INDEX*16 + DM_EN_DISP];

    // R10: a strobe is answered in the next cycle
    p_rvalid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);
    p_rvalid_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);
    // R2: index 0 always answers with the ID code
    p_id_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (region == RG_MODE) && (mode_idx == '0))
        |=> (bus_rdata == {16'h0000, DM_ID_VALUE}));
    // R3: index NREG answers with the memory size
    p_memsize_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (region == RG_MODE) && (int'(mode_idx) == NREG))
        |=> (bus_rdata == 32'(MEM_UNITS)));
    // R9: foreign pages answer zero
    p_foreign_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (region == RG_NONE)) |=> (bus_rdata == 32'h0));
endmodule

// File: tb/dm_regif_tb.sv
`timescale 1ns/1ps
module dm_regif_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [31:0]  bus_rdata;
    logic         bus_rvalid;
    logic [159:0] mode_regs_o;
    logic         display_en_o;
    logic         big_endian_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dm_regif u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .mode_regs_o(mode_regs_o),
        .display_en_o(display_en_o), .big_endian_o(big_endian_o)
    );

    // behavioural reference model
    int          m_reg [10];
    bit          m_big;
    bit          m_valid;
    logic [31:0] m_data;

    function automatic logic [31:0] model_read(logic [11:0] a);
        int idx;
        if (a[11:8] == 4'h5) begin
            idx = int'(a[7:1]);
            if (idx == 0)       return 32'h0000B0C5;
            else if (idx < 10)  return 32'(m_reg[idx]);
            else if (idx == 10) return 32'h100;
            else                return 32'h0000FFFF;
        end else if (a[11:8] == 4'h6) begin
            if (a[7:0] == 8'h00) return 32'd8;
            if (a[7:0] == 8'h04) return m_big ? 32'hBEBEBEBE : 32'h1E1E1E1E;
            return 32'h0;
        end
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 10; i++) m_reg[i] = 0;
            m_big   = 1'b0;
            m_valid = 1'b0;
            m_data  = '0;
        end else begin
            m_valid = bus_rd;
            if (bus_rd) m_data = model_read(bus_addr);
            if (bus_wr) begin
                if (bus_addr[11:8] == 4'h5 && int'(bus_addr[7:1]) < 10)
                    m_reg[int'(bus_addr[7:1])] = int'(bus_wdata[15:0]);
                if (bus_addr == 12'h604 && bus_wdata == 32'hBEBEBEBE) m_big = 1'b1;
                if (bus_addr == 12'h604 && bus_wdata == 32'h1E1E1E1E) m_big = 1'b0;
            end
        end
    end

    task automatic check(string tag, logic [159:0] got, logic [159:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model (R10, R11)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R10 rvalid", 160'(bus_rvalid), 160'(m_valid));
            if (m_valid) check("R10 rdata", 160'(bus_rdata), 160'(m_data));
            for (int i = 0; i < 10; i++)
                check("R11 mode_regs", 160'(mode_regs_o[i*16 +: 16]), 160'(m_reg[i]));
            check("R11 display_en", 160'(display_en_o), 160'(m_reg[4] & 1));
            check("R7 big_endian", 160'(big_endian_o), 160'(m_big));
        end
    end

    task automatic wr_op(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_op(logic [11:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
        @(negedge clk);
        bus_rd = 1'b0;
        check(tag, 160'(bus_rdata), 160'(exp));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 regs zero", mode_regs_o, '0);
        check("R1 little endian", 160'(big_endian_o), 160'(0));
        check("R1 rvalid low", 160'(bus_rvalid), 160'(0));
        rd_op(12'h604, 32'h1E1E1E1E, "R1 order word");
        // R2 ID
        rd_op(12'h500, 32'h0000B0C5, "R2 id");
        wr_op(12'h500, 32'h00001234);
        rd_op(12'h500, 32'h0000B0C5, "R2 id after write");
        check("R2 stored index 0", 160'(mode_regs_o[15:0]), 160'(16'h1234));
        // R3 memory size
        rd_op(12'h514, 32'h00000100, "R3 memsize");
        wr_op(12'h514, 32'h0000ABCD);
        rd_op(12'h514, 32'h00000100, "R3 memsize after write");
        // R4 stored registers
        for (int i = 1; i < 10; i++) wr_op(12'h500 + 12'(2*i), 32'hFFFF0000 | 32'(16'h1100 + i*16'h0111));
        for (int i = 1; i < 10; i++) rd_op(12'h500 + 12'(2*i), 32'(16'h1100 + i*16'h0111), "R4 readback");
        wr_op(12'h503, 32'h00005A5A);
        rd_op(12'h502, 32'h00005A5A, "R4 odd byte address");
        // R5 beyond storage
        wr_op(12'h516, 32'h00007777);
        wr_op(12'h5FE, 32'h00008888);
        rd_op(12'h516, 32'h0000FFFF, "R5 index 11");
        rd_op(12'h5FF, 32'h0000FFFF, "R5 index 127");
        check("R5 exports kept", 160'(mode_regs_o[31:16]), 160'(16'h5A5A));
        // R6 size word
        rd_op(12'h600, 32'd8, "R6 ext size");
        // R7 / R8 byte order
        wr_op(12'h604, 32'hBEBEBEBE);
        rd_op(12'h604, 32'hBEBEBEBE, "R7 big");
        check("R7 big flag", 160'(big_endian_o), 160'(1));
        wr_op(12'h604, 32'h12345678);
        rd_op(12'h604, 32'hBEBEBEBE, "R8 other value keeps big");
        wr_op(12'h604, 32'h1E1E1E1E);
        rd_op(12'h604, 32'h1E1E1E1E, "R7 little");
        wr_op(12'h604, 32'hBEBEBEBF);
        rd_op(12'h604, 32'h1E1E1E1E, "R8 near miss keeps little");
        check("R8 flag low", 160'(big_endian_o), 160'(0));
        // R9 unused space
        rd_op(12'h608, 32'h0, "R9 ext offset 8");
        rd_op(12'h602, 32'h0, "R9 ext offset 2");
        wr_op(12'h700, 32'hBEBEBEBE);
        wr_op(12'h008, 32'h00000001);
        rd_op(12'h000, 32'h0, "R9 page 0");
        rd_op(12'h7FC, 32'h0, "R9 page 7");
        check("R9 flag unchanged", 160'(big_endian_o), 160'(0));
        // R11 display enable
        wr_op(12'h508, 32'h00000041);
        check("R11 display on", 160'(display_en_o), 160'(1));
        wr_op(12'h508, 32'h00000040);
        check("R11 display off", 160'(display_en_o), 160'(0));
        // R12 read and write in the same cycle
        @(negedge clk);
        bus_addr = 12'h506; bus_wdata = 32'h0000C3C3; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        check("R12 old value", 160'(bus_rdata), 160'(16'h1100 + 3*16'h0111));
        rd_op(12'h506, 32'h0000C3C3, "R12 new value after");
        // R10 back-to-back reads
        @(negedge clk);
        bus_addr = 12'h500; bus_rd = 1'b1;
        @(negedge clk);
        check("R10 first", 160'(bus_rdata), 160'(32'h0000B0C5));
        bus_addr = 12'h600;
        @(negedge clk);
        check("R10 second", 160'(bus_rdata), 160'(32'd8));
        check("R10 valid held", 160'(bus_rvalid), 160'(1));
        bus_rd = 1'b0;
        @(negedge clk);
        check("R10 valid drops", 160'(bus_rvalid), 160'(0));
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule